// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned integer by another over several clock cycles. It produces one quotient bit per clock. A one-cycle start pulse, accepted only while the unit is idle, captures a dividend and a divisor. The divisor stays fixed for the whole operation.

On every working cycle the top bit of the captured dividend enters the bottom of a partial remainder, and the dividend register moves left by one place. The widened remainder is then compared against the divisor. If it is at least the divisor, a 1 enters the quotient and the divisor is taken away from the remainder. Otherwise a 0 enters the quotient and the remainder keeps the shifted value.

After exactly `WIDTH` such cycles a one-cycle done pulse marks the results as valid. The quotient and remainder then stay on the outputs until the next accepted start. Division by zero needs no special path: the same steps produce an all-ones quotient and return the dividend as the remainder, and no trap is raised.

Top module: `restoring_divider`

## Requirements
- R1: After reset, busy_o and done_o are 0 and quotient_o and remainder_o are all zeros.
- R2: A start_i high at a clock edge while busy_o is 0 is accepted, and busy_o is 1 after that edge.
- R3: An accepted start is followed by exactly WIDTH working cycles. At the WIDTH-th edge after the accepting edge, busy_o falls and done_o is high for that one cycle only.
- R4: With a non-zero divisor, quotient_o equals the integer quotient of dividend by divisor and remainder_o equals the dividend modulo the divisor, whenever done_o is high.
- R5: A start_i high while busy_o is 1 is ignored. The running operation keeps its timing and its operands, and its result is the one for the originally captured pair.
- R6: With a divisor of zero, quotient_o is all ones and remainder_o equals the dividend.
- R7: While idle and with no accepted start, quotient_o and remainder_o hold their last values, whatever dividend_i and divisor_i do.
- R8: With WIDTH = 5, a dividend of 11101 and a divisor of 00011 give quotient 01001 and remainder 00010.
- R9: When done_o is high and the divisor is non-zero, remainder_o is less than the divisor.
- R10: A start_i held high through the done cycle is accepted at the next edge, so back-to-back divisions need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a division |
| dividend_i | input | WIDTH | Numerator, captured on an accepted start |
| divisor_i | input | WIDTH | Denominator, captured on an accepted start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quotient_o | output | WIDTH | Quotient, held until the next accepted start |
| remainder_o | output | WIDTH | Remainder, held until the next accepted start |

## Verification
The bench builds the divider with WIDTH = 5. At this size every one of the 1024 operand pairs can be swept, including all 32 divide-by-zero cases and the worked example 29 / 3. Directed sequences then overlap a second start with a running division, hold start high through done, and leave the unit idle while the operand inputs toggle. A behavioural model in the bench predicts busy, done and the held results on every clock, using the language's own division and modulo operators.

// File: rtl/div_pkg.sv
package div_pkg;

    // Control sequencer states
    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/div_step.sv
// One restoring iteration: shift a dividend bit into the partial
// remainder, trial-compare against the divisor, subtract on success.
module div_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic             bit_in_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] rem_o,
    output logic             qbit_o
);
    localparam int XW = WIDTH + 1;

    logic [XW-1:0] trial;
    logic [XW-1:0] wide_dsr;
    logic [XW-1:0] diff;

    always_comb begin
        trial    = {rem_i, bit_in_i};
        wide_dsr = {1'b0, divisor_i};
        diff     = trial - wide_dsr;
        qbit_o   = (trial >= wide_dsr);
        rem_o    = qbit_o ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    end

endmodule

// File: rtl/div_ctrl.sv
// Iteration sequencer: accepts a start while idle, counts WIDTH steps.
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic last_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    typedef struct packed {
        ctrl_state_e   state;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d   = ctrl_q;
        accept_o = start_i && (ctrl_q.state == CTRL_IDLE);
        busy_o   = (ctrl_q.state == CTRL_RUN);
        last_o   = busy_o && (ctrl_q.cnt == LAST_IDX);
        if (accept_o) begin
            ctrl_d.state = CTRL_RUN;
            ctrl_d.cnt   = '0;
        end else if (busy_o) begin
            if (last_o) begin
                ctrl_d.state = CTRL_IDLE;
                ctrl_d.cnt   = '0;
            end else begin
                ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: CTRL_IDLE, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R3: the step counter never passes the last iteration index
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctrl_q.cnt <= LAST_IDX));

    // R3: the run state lasts until the last index, then returns to idle
    a_r3_last_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/restoring_divider.sv
// Multi-cycle unsigned restoring divider, one quotient bit per clock.
module restoring_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    typedef struct packed {
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dvd;
        logic [WIDTH-1:0] dsr;
        logic             done;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             accept;
    logic             last;
    logic [WIDTH-1:0] step_rem;
    logic             step_qbit;

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .last_o   (last)
    );

    div_step #(.WIDTH(WIDTH)) u_step (
        .rem_i     (dp_q.rem),
        .bit_in_i  (dp_q.dvd[WIDTH-1]),
        .divisor_i (dp_q.dsr),
        .rem_o     (step_rem),
        .qbit_o    (step_qbit)
    );

    always_comb begin
        dp_d      = dp_q;
        dp_d.done = 1'b0;
        if (accept) begin
            dp_d.rem = '0;
            dp_d.quo = '0;
            dp_d.dvd = dividend_i;
            dp_d.dsr = divisor_i;
        end else if (busy_o) begin
            dp_d.rem  = step_rem;
            dp_d.quo  = WIDTH'({dp_q.quo, step_qbit});
            dp_d.dvd  = dp_q.dvd << 1;
            dp_d.done = last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign done_o      = dp_q.done;
    assign quotient_o  = dp_q.quo;
    assign remainder_o = dp_q.rem;

    // R2: an idle start makes the unit busy on the next cycle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3: done only appears on the cycle busy has just dropped
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R5: a start during a run leaves the captured divisor alone
    a_r5_hold_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(dp_q.dsr));

    // R6: a zero divisor yields an all-ones quotient
    a_r6_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (dp_q.dsr == '0)) |-> (&quotient_o));

    // R7: idle with no start keeps the results on the outputs
    a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

    // R9: the final remainder is below a non-zero divisor
    a_r9_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (dp_q.dsr != '0)) |-> (remainder_o < dp_q.dsr));

endmodule

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;

    localparam int W       = 5;
    localparam int MAXV    = (1 << W) - 1;
    localparam int LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    restoring_divider #(.WIDTH(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    // Behavioural reference model, advanced at each rising edge
    int m_busy = 0, m_left = 0, m_done = 0;
    int m_a = 0, m_b = 0, exp_q = 0, exp_r = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_left = 0; m_done = 0;
            exp_q = 0; exp_r = 0; m_a = 0; m_b = 0;
        end else begin
            m_done = 0;
            if (m_busy == 0 && start_i) begin
                m_busy = 1; m_left = W;
                m_a = int'(dividend_i); m_b = int'(divisor_i);
            end else if (m_busy != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1;
                    exp_q = (m_b == 0) ? MAXV : m_a / m_b;
                    exp_r = (m_b == 0) ? m_a : m_a % m_b;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check(int'(busy_o) == m_busy, "R2", "busy", int'(busy_o), m_busy);
            check(int'(done_o) == m_done, "R3", "done", int'(done_o), m_done);
            if (m_busy == 0) begin
                // R7: idle results hold; R4 / R6 by divisor value
                check(int'(quotient_o) == exp_q, (m_b == 0) ? "R6" : "R4",
                      "quotient", int'(quotient_o), exp_q);
                check(int'(remainder_o) == exp_r, (m_b == 0) ? "R6" : "R4",
                      "remainder", int'(remainder_o), exp_r);
            end
            if (done_o && m_b != 0)
                check(int'(remainder_o) < m_b, "R9", "remainder bound",
                      int'(remainder_o), m_b);
        end
    end

    task automatic run_div(input int a, input int b);
        @(negedge clk);
        start_i = 1'b1; dividend_i = W'(a); divisor_i = W'(b);
        @(negedge clk);
        start_i = 1'b0;
        repeat (W) @(negedge clk);
    endtask

    task automatic summary();
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(LIMIT * 4);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags", int'(busy_o), 0);
        check(quotient_o == '0 && remainder_o == '0, "R1", "results",
              int'(quotient_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: worked example 29 / 3
        run_div(29, 3);
        check(done_o == 1'b1, "R3", "done at step W", int'(done_o), 1);
        check(quotient_o == 5'b01001, "R8", "quotient", int'(quotient_o), 9);
        check(remainder_o == 5'b00010, "R8", "remainder", int'(remainder_o), 2);

        // R5: second start during a run is ignored
        @(negedge clk);
        start_i = 1'b1; dividend_i = 5'd29; divisor_i = 5'd4;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; dividend_i = 5'd7; divisor_i = 5'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (W - 2) @(negedge clk);
        check(done_o == 1'b1, "R5", "done timing", int'(done_o), 1);
        check(quotient_o == 5'd7 && remainder_o == 5'd1, "R5", "quotient",
              int'(quotient_o), 7);

        // R7: idle with toggling operand inputs
        repeat (4) begin
            @(negedge clk);
            dividend_i = ~dividend_i; divisor_i = divisor_i + 5'd3;
        end
        @(negedge clk);
        check(quotient_o == 5'd7 && remainder_o == 5'd1, "R7", "held result",
              int'(quotient_o), 7);

        // R10: start held through done, back-to-back
        @(negedge clk);
        start_i = 1'b1; dividend_i = 5'd20; divisor_i = 5'd6;
        repeat (W + 1) @(negedge clk);
        check(done_o == 1'b1 && quotient_o == 5'd3 && remainder_o == 5'd2,
              "R10", "first result", int'(quotient_o), 3);
        dividend_i = 5'd31; divisor_i = 5'd4;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10", "re-accept", int'(busy_o), 1);
        repeat (W) @(negedge clk);
        check(done_o == 1'b1 && quotient_o == 5'd7 && remainder_o == 5'd3,
              "R10", "second result", int'(quotient_o), 7);

        // R4 / R6: every operand pair, zero divisor included
        for (int b = 0; b <= MAXV; b++) begin
            for (int a = 0; a <= MAXV; a++) begin
                run_div(a, b);
            end
        end

        repeat (3) @(negedge clk);
        summary();
    end

endmodule